// File: doc/BRIEF.md
# Prescaled Countdown Timer Bank

This block holds a parameterised number of independent down-counters (six by default) behind a flat word-addressed register port. Each channel chooses one of four externally generated tick-enable inputs. It divides that source by a power of two from 1 to 128 and counts its own register down on every divided tick. When the count runs out, the channel either reloads its interval and carries on, or stops and clears its own enable.

A shared status register latches one expiry flag per channel. Software clears these flags by writing ones to the bits it wants cleared. A shared mask register selects which flags reach the per-channel interrupt outputs. Read data is combinational from the address, and writes take effect at the clock edge on which the write strobe is sampled high.

Top module: `timer_bank`

## Requirements
- R1: Registers are 32-bit words at byte offsets: interrupt mask at 0x000 and status at 0x004. Channel c (0-based) has control at 0x10*(c+1)+0x0, interval at +0x4 and count at +0x8. Every other offset in the 0x400 window, including unaligned ones, reads 0, and a write there changes no register.
- R2: While rst_ni is low, mask, status, intervals and counts are 0, every control register is 0x04 (source 1, divide by 1, stopped) and all irq_o bits are 0.
- R3: Control bits [3:2] select the tick source and bits [6:4] hold a prescale exponent p. A running channel changes its count once on every 2^p-th tick of the selected source. The prescale phase restarts on every control write, so the first change falls on the 2^p-th source tick after that write.
- R4: A control write with bit 1 set loads the count from the interval register. Without bit 1 the count is left as it was. A write to the count register loads the live counter, and a read of it returns the live value.
- R5: Control bit 0 enables counting. With bit 0 clear the count holds.
- R6: A divided tick that finds the count at 1 or 0 is an expiry. It sets the channel's status bit, and with control bit 7 clear the count reloads the interval. Otherwise a divided tick decrements the count by one. The period is therefore `interval` divided ticks.
- R7: With control bit 7 set (one-shot), an expiry leaves the count at 0 and clears control bit 0, so that the channel stays stopped.
- R8: Writing the status register clears each bit written as 1 and leaves bits written as 0 unchanged. An expiry in the same cycle as a clear wins.
- R9: irq_o[c] is high exactly while status bit c and mask bit c are both set.

Top module port list:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W (10) | Byte address of the access |
| wdata_i | input | DATA_W (32) | Write data |
| we_i | input | 1 | Write strobe, one write per cycle high |
| rdata_o | output | DATA_W (32) | Read data for addr_i, combinational |
| src_tick_i | input | N_SRC (4) | Tick-enable inputs, one per clock source |
| irq_o | output | N_CH (6) | Per-channel interrupt, status AND mask |

## Verification
Read data depends on the address alone, so a value is sampled 1 ns after the address is set at a falling edge, with no clock edge in between. A register write commits on the rising edge that follows the falling edge where the strobe goes high. The bench counts divided ticks from that edge onward: after n further rising edges on an always-on source, the count is expected to equal the interval minus n shifted right by p. An expiry flag and its interrupt are therefore due right after the edge that holds the tick at count 1, which is the third edge for an interval of 3. The bench waits that exact number of falling edges before each read, so that every expected value follows from edge counts and not from sampling races.

// File: rtl/timer_bank_pkg.sv
package timer_bank_pkg;
  localparam int CTRL_W      = 8;
  localparam int CB_EN       = 0;
  localparam int CB_RELOAD   = 1;
  localparam int CB_SRC_LO   = 2;
  localparam int SRC_W       = 2;
  localparam int CB_PS_LO    = 4;
  localparam int PS_W        = 3;
  localparam int CB_ONESHOT  = 7;
  localparam logic [CTRL_W-1:0] CTRL_RST = 8'h04;

  localparam int OFF_MASK    = 'h000;
  localparam int OFF_STATUS  = 'h004;
  localparam int CH_STRIDE   = 'h10;
  localparam int OFF_CTRL    = 'h0;
  localparam int OFF_INTV    = 'h4;
  localparam int OFF_CNT     = 'h8;

  function automatic int ch_addr(int ch, int off);
    return CH_STRIDE * (ch + 1) + off;
  endfunction
endpackage

// File: rtl/timer_prescaler.sv
module timer_prescaler
  import timer_bank_pkg::*;
#(
  parameter int PSW = PS_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           src_tick_i,
  input  logic           run_i,
  input  logic           restart_i,
  input  logic [PSW-1:0] ps_i,
  output logic           tick_o
);
  localparam int DIV_W = (1 << PSW) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  assign mask   = DIV_W'((1 << ps_i) - 1);
  assign tick_o = run_i && src_tick_i && ((div_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  div_q <= '0;
    else if (restart_i)           div_q <= '0;
    else if (run_i && src_tick_i) div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/timer_channel.sv
module timer_channel
  import timer_bank_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int N_SRC  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  src_tick_i,
  input  logic              wr_ctrl_i,
  input  logic              wr_intv_i,
  input  logic              wr_cnt_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [DATA_W-1:0] intv_o,
  output logic [DATA_W-1:0] cnt_o,
  output logic              expire_o
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [DATA_W-1:0] intv_q, cnt_q;
  logic              wr_any, en, oneshot, sel_tick, tick;
  logic [SRC_W-1:0]  src_sel;

  assign wr_any   = wr_ctrl_i | wr_intv_i | wr_cnt_i;
  assign en       = ctrl_q[CB_EN];
  assign oneshot  = ctrl_q[CB_ONESHOT];
  assign src_sel  = ctrl_q[CB_SRC_LO +: SRC_W];
  assign sel_tick = src_tick_i[src_sel];

  timer_prescaler #(.PSW(PS_W)) u_pre (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .src_tick_i (sel_tick),
    .run_i      (en & ~wr_any),
    .restart_i  (wr_ctrl_i),
    .ps_i       (ctrl_q[CB_PS_LO +: PS_W]),
    .tick_o     (tick)
  );

  assign expire_o = tick && (cnt_q <= DATA_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_RST;
    end else if (wr_ctrl_i) begin
      ctrl_q <= wdata_i[CTRL_W-1:0];
    end else if (expire_o && oneshot) begin
      ctrl_q[CB_EN] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        intv_q <= '0;
    else if (wr_intv_i) intv_q <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (wr_ctrl_i && wdata_i[CB_RELOAD]) begin
      cnt_q <= intv_q;
    end else if (wr_cnt_i) begin
      cnt_q <= wdata_i;
    end else if (tick) begin
      if (expire_o) cnt_q <= oneshot ? '0 : intv_q;
      else          cnt_q <= cnt_q - 1'b1;
    end
  end

  assign ctrl_o = ctrl_q;
  assign intv_o = intv_q;
  assign cnt_o  = cnt_q;

  AST_STOPPED_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en && !wr_any) |=> $stable(cnt_q)); // R5
  AST_DECREMENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && cnt_q > DATA_W'(1)) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R6
  AST_PERIODIC_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_o && !oneshot) |=> (cnt_q == $past(intv_q))); // R6
  AST_ONESHOT_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_o && oneshot) |=> (!ctrl_q[CB_EN] && cnt_q == '0)); // R7
endmodule

// File: rtl/timer_bank.sv
module timer_bank
  import timer_bank_pkg::*;
#(
  parameter int N_CH   = 6,
  parameter int N_SRC  = 4,
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [N_SRC-1:0]  src_tick_i,
  output logic [N_CH-1:0]   irq_o
);
  localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(OFF_MASK);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFF_STATUS);

  logic [N_CH-1:0]   mask_q, status_q, expire, clr_mask;
  logic [N_CH-1:0]   wr_ctrl, wr_intv, wr_cnt;
  logic [CTRL_W-1:0] ch_ctrl [N_CH];
  logic [DATA_W-1:0] ch_intv [N_CH];
  logic [DATA_W-1:0] ch_cnt  [N_CH];

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ch_addr(c, OFF_CTRL));
    localparam logic [ADDR_W-1:0] A_INTV = ADDR_W'(ch_addr(c, OFF_INTV));
    localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(ch_addr(c, OFF_CNT));

    assign wr_ctrl[c] = we_i && (addr_i == A_CTRL);
    assign wr_intv[c] = we_i && (addr_i == A_INTV);
    assign wr_cnt[c]  = we_i && (addr_i == A_CNT);

    timer_channel #(.DATA_W(DATA_W), .N_SRC(N_SRC)) u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .src_tick_i (src_tick_i),
      .wr_ctrl_i  (wr_ctrl[c]),
      .wr_intv_i  (wr_intv[c]),
      .wr_cnt_i   (wr_cnt[c]),
      .wdata_i    (wdata_i),
      .ctrl_o     (ch_ctrl[c]),
      .intv_o     (ch_intv[c]),
      .cnt_o      (ch_cnt[c]),
      .expire_o   (expire[c])
    );
  end

  assign clr_mask = (we_i && addr_i == A_STATUS) ? wdata_i[N_CH-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           mask_q <= '0;
    else if (we_i && addr_i == A_MASK)     mask_q <= wdata_i[N_CH-1:0];
  end

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~clr_mask) | expire;
  end

  assign irq_o = status_q & mask_q;

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_MASK)   rdata_o[N_CH-1:0] = mask_q;
    if (addr_i == A_STATUS) rdata_o[N_CH-1:0] = status_q;
    for (int c = 0; c < N_CH; c++) begin
      if (addr_i == ADDR_W'(ch_addr(c, OFF_CTRL))) rdata_o[CTRL_W-1:0] = ch_ctrl[c];
      if (addr_i == ADDR_W'(ch_addr(c, OFF_INTV))) rdata_o = ch_intv[c];
      if (addr_i == ADDR_W'(ch_addr(c, OFF_CNT)))  rdata_o = ch_cnt[c];
    end
  end

  AST_STATUS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_q & $past(status_q & ~clr_mask)) == $past(status_q & ~clr_mask))); // R8
  AST_EXPIRY_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|expire) |=> ((status_q & $past(expire)) == $past(expire))); // R8
  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(irq_o & ~mask_q)) == 1'b0); // R9
endmodule

// File: tb/timer_bank_tb.sv
`timescale 1ns/1ps
module timer_bank_tb;
  localparam int N_CH = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0;
  logic [31:0] rdata;
  logic [3:0]  src = '0;
  logic [5:0]  irq;
  int vec = 0, err = 0;
  bit done = 0;

  always #4 clk = ~clk;

  timer_bank u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .we_i(we),
    .rdata_o(rdata), .src_tick_i(src), .irq_o(irq)
  );

  function automatic int ca(int c, int off);
    return 16 * (c + 1) + off;
  endfunction

  function automatic bit defined(int a);
    return a == 0 || a == 4 || (a >= 16 && a < 16 * (N_CH + 1) && (a % 16) <= 8 && (a % 4) == 0);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk); addr = a[9:0]; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    addr = a[9:0]; #1; d = rdata;
  endtask

  task automatic rchk(string req, int a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic pulse(logic [3:0] m);
    src = m; @(negedge clk); src = '0; @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      vec++; err++;
      $display("FAIL watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vec, err);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    // R2 reset state
    rchk("R2 mask", 0, 0);
    rchk("R2 status", 4, 0);
    for (int c = 0; c < N_CH; c++) begin
      rchk("R2 ctrl", ca(c, 0), 32'h04);
      rchk("R2 intv", ca(c, 4), 0);
      rchk("R2 cnt", ca(c, 8), 0);
    end
    chk("R2 irq", {26'b0, irq}, 0);
    @(negedge clk); rst_n = 1'b1;

    // R3 prescale sweep on always-on source 0
    src = 4'b0001;
    for (int p = 0; p < 4; p++) begin
      wr(ca(p, 4), 40);
      wr(ca(p, 0), 32'h03 | (p << 4));
      for (int n = 0; n <= 20; n++) begin
        rchk("R3 count", ca(p, 8), 40 - (n >> p));
        @(negedge clk);
      end
      wr(ca(p, 0), p << 4);
      rd(ca(p, 8), v);
      repeat (5) @(negedge clk);
      rchk("R5 stopped holds", ca(p, 8), v);
    end

    // R3 source select: ch1 source 2, divide by 2
    src = '0;
    wr(ca(1, 4), 30);
    wr(ca(1, 0), 32'h1B);
    for (int k = 0; k < 3; k++) begin pulse(4'b0001); pulse(4'b0010); pulse(4'b1000); end
    rchk("R3 other sources ignored", ca(1, 8), 30);
    pulse(4'b0100);
    rchk("R3 first src tick", ca(1, 8), 30);
    pulse(4'b0100);
    rchk("R3 second src tick", ca(1, 8), 29);
    for (int k = 0; k < 3; k++) pulse(4'b0100);
    rchk("R3 five src ticks", ca(1, 8), 28);
    wr(ca(1, 0), 32'h18);
    src = 4'b0001;

    // R6 periodic ch2 interval 3
    wr(ca(2, 4), 3);
    wr(ca(2, 0), 32'h03);
    repeat (2) @(negedge clk);
    rchk("R6 count before expiry", ca(2, 8), 1);
    rchk("R6 status before expiry", 4, 0);
    @(negedge clk);
    rchk("R6 reloaded", ca(2, 8), 3);
    rchk("R6 status set", 4, 32'h4);
    chk("R9 masked irq", {26'b0, irq}, 0);
    wr(0, 32'h4);
    chk("R9 irq on", {26'b0, irq}, 32'h4);
    wr(ca(2, 0), 32'h00);
    wr(4, 32'h0);
    rchk("R8 zero write keeps", 4, 32'h4);
    wr(4, 32'hFFFF_FFFB);
    rchk("R8 other bits keep", 4, 32'h4);
    wr(4, 32'h4);
    rchk("R8 w1c clears", 4, 0);
    chk("R9 irq off", {26'b0, irq}, 0);

    // R7 one-shot ch3 interval 4
    wr(ca(3, 4), 4);
    wr(ca(3, 0), 32'h83);
    repeat (3) @(negedge clk);
    rchk("R7 count before", ca(3, 8), 1);
    rchk("R7 ctrl before", ca(3, 0), 32'h83);
    @(negedge clk);
    rchk("R7 count zero", ca(3, 8), 0);
    rchk("R7 enable cleared", ca(3, 0), 32'h82);
    rchk("R6 status oneshot", 4, 32'h8);
    chk("R9 irq masked", {26'b0, irq}, 0);
    repeat (10) @(negedge clk);
    rchk("R7 stays stopped", ca(3, 8), 0);
    wr(0, 32'h8);
    chk("R9 irq ch3", {26'b0, irq}, 32'h8);

    // R4 reload bit
    wr(ca(4, 4), 9);
    wr(ca(4, 0), 32'h02);
    rchk("R4 reload loads", ca(4, 8), 9);
    repeat (5) @(negedge clk);
    rchk("R5 disabled holds", ca(4, 8), 9);
    wr(ca(4, 4), 20);
    wr(ca(4, 0), 32'h0D);
    rchk("R4 no reload keeps", ca(4, 8), 9);
    repeat (5) @(negedge clk);
    rchk("R3 idle source", ca(4, 8), 9);
    wr(ca(5, 8), 32'h1234_5678);
    rchk("R4 count write", ca(5, 8), 32'h1234_5678);

    // R1 undefined offsets
    for (int a = 0; a < 1024; a += 4) if (!defined(a)) wr(a, 32'hFFFF_FFFF);
    for (int a = 0; a < 1024; a += 4) if (!defined(a)) rchk("R1 undefined reads 0", a, 0);
    rchk("R1 unaligned reads 0", 'h12, 0);
    rchk("R1 mask intact", 0, 32'h8);
    rchk("R1 status intact", 4, 32'h8);
    rchk("R1 count intact", ca(5, 8), 32'h1234_5678);
    rchk("R1 ctrl intact", ca(4, 0), 32'h0D);
    rchk("R1 intv intact", ca(4, 4), 20);

    // R2 reset while active
    @(negedge clk); rst_n = 1'b0;
    rchk("R2 mask", 0, 0);
    rchk("R2 status", 4, 0);
    rchk("R2 ctrl", ca(4, 0), 32'h04);
    rchk("R2 intv", ca(4, 4), 0);
    rchk("R2 cnt", ca(5, 8), 0);
    chk("R2 irq", {26'b0, irq}, 0);
    @(negedge clk); rst_n = 1'b1;

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, err);
    $finish;
  end
endmodule